// File: doc/BRIEF.md
# Programmable Retriggerable One-Shot Timer

This block is a monostable pulse generator timed by a master tick enable. A qualifying edge on the trigger input moves the output to its active level. The output stays there for a selectable number of master ticks, then falls back to its idle level. The width code picks one of eight lengths, each eight times the previous, from 1 tick up to 2^21 ticks. An external code decoder supplies the width code and the output polarity bit.

Two build options set the variant. One picks the trigger edge: rising or falling. The other picks retriggering: either later edges restart the timing, or they are ignored until the pulse ends and a short rearm interval has passed. After reset, a start-up phase counts master ticks. During it the output is held low and triggers are ignored. At its end the output settles to the idle level that the polarity bit selects. The trigger input is asynchronous and goes through a two-flop synchronizer before edge detection.

Top module: `oneshot_timer`

## Requirements
- R1: With width code k on `width_sel` (0 to 7), an accepted trigger gives a pulse that lasts exactly 8^k master ticks: code 0 gives 1, code 1 gives 8, and so on up to code 7, which gives 2^21.
- R2: With RISE_TRIG=1 only a 0-to-1 transition of the synchronized trigger starts a pulse. With RISE_TRIG=0 only a 1-to-0 transition does. The opposite transition has no effect.
- R3: With RETRIG=0, trigger edges that arrive while the pulse is active neither extend nor restart it.
- R4: After every pulse, trigger edges are ignored for REARM_TICKS master ticks. An edge arriving on the first cycle after that interval is accepted.
- R5: With RETRIG=1, each accepted edge during an active pulse restarts the count. The pulse ends 8^k ticks after the last edge, so repeated edges can extend it without limit.
- R6: When `inv_pol` is 0 the idle level is low and the pulse is high. When `inv_pol` is 1 the idle level is high and the pulse is low.
- R7: For STARTUP_TICKS master ticks after reset, `pulse_out` is held low and trigger edges are ignored.
- R8: On the cycle after the last start-up tick, `pulse_out` takes the idle level, which is high when `inv_pol` is 1. Triggers are accepted from then on.
- R9: While `tick_en` is low an active pulse does not advance. It ends only after the remaining ticks arrive.
- R10: The output becomes active on the third rising clock edge after the trigger input changes: two synchronizer stages plus one state update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Master tick, one clock wide, timing base for all intervals |
| trig_in | input | 1 | Asynchronous trigger input |
| width_sel | input | SEL_W | Width code k; pulse lasts 8^k ticks |
| inv_pol | input | 1 | Output polarity: 0 active-high, 1 active-low |
| pulse_out | output | 1 | Pulse output |

## Verification
A corrupted tick counter or phase register shows at the output as a pulse of the wrong width, measured in clock cycles with the tick held high, or as a pulse that appears or goes missing after an edge. Wrong start-up handling shows on the exact cycle the idle level appears. A wrong rearm or retrigger decision moves the end of the pulse, or adds or removes a whole pulse, within about a dozen cycles of the trigger edge. Each case is checked against a queue of expected widths, so a missing or extra pulse is reported as well as a wrong width.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
   typedef enum logic [1:0] {
      PH_START  = 2'd0,
      PH_IDLE   = 2'd1,
      PH_ACTIVE = 2'd2,
      PH_REARM  = 2'd3
   } phase_t;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/trig_edge_det.sv
module trig_edge_det #(
   parameter int STAGES    = 2,
   parameter bit RISE_TRIG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic edge_o
);
   localparam logic IDLE_LVL = RISE_TRIG ? 1'b0 : 1'b1;

   if (STAGES < 2) begin : g_bad_stages
      $error("trig_edge_det: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= {STAGES{IDLE_LVL}};
         prev_q <= IDLE_LVL;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], din};
         prev_q <= sync_q[STAGES-1];
      end
   end

   if (RISE_TRIG) begin : g_rise
      assign edge_o = sync_q[STAGES-1] & ~prev_q;
   end else begin : g_fall
      assign edge_o = ~sync_q[STAGES-1] & prev_q;
   end

   // R2: a detected edge cannot repeat on the next cycle
   a_r2_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |=> !edge_o);
endmodule

// File: rtl/width_select.sv
module width_select #(
   parameter int SEL_W     = 3,
   parameter int STEP_LOG2 = 3,
   parameter int CNT_W     = 22
) (
   input  logic [SEL_W-1:0] sel,
   output logic [CNT_W-1:0] last_cnt
);
   localparam int NSEL = 2 ** SEL_W;

   if (CNT_W < STEP_LOG2 * (NSEL - 1) + 1) begin : g_bad_width
      $error("width_select: CNT_W too narrow for the largest width");
   end

   always_comb begin
      last_cnt = '0;
      for (int i = 0; i < NSEL; i++) begin
         if (sel == SEL_W'(i))
            last_cnt = (CNT_W'(1) << (STEP_LOG2 * i)) - CNT_W'(1);
      end
   end
endmodule

// File: rtl/oneshot_core.sv
module oneshot_core
   import oneshot_pkg::*;
#(
   parameter int CNT_W         = 22,
   parameter int STARTUP_TICKS = 500,
   parameter int REARM_TICKS   = 2,
   parameter bit RETRIG        = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             trig_edge,
   input  logic [CNT_W-1:0] last_cnt,
   output logic             active,
   output logic             ready
);
   localparam bit HAS_REARM  = (REARM_TICKS > 0);
   localparam int REARM_LAST = HAS_REARM ? REARM_TICKS - 1 : 0;
   localparam logic [CNT_W-1:0] START_LAST = CNT_W'(STARTUP_TICKS - 1);
   localparam logic [CNT_W-1:0] RARM_LAST  = CNT_W'(REARM_LAST);

   if (STARTUP_TICKS < 1) begin : g_bad_start
      $error("oneshot_core: STARTUP_TICKS must be at least 1");
   end
   if (REARM_TICKS < 0) begin : g_bad_rearm
      $error("oneshot_core: REARM_TICKS must not be negative");
   end

   phase_t           phase_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_START;
         cnt_q   <= '0;
      end else begin
         unique case (phase_q)
            PH_START: begin
               if (tick) begin
                  if (cnt_q == START_LAST) begin
                     phase_q <= PH_IDLE;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            PH_IDLE: begin
               if (trig_edge) begin
                  phase_q <= PH_ACTIVE;
                  cnt_q   <= '0;
               end
            end
            PH_ACTIVE: begin
               if (RETRIG && trig_edge) begin
                  cnt_q <= '0;
               end else if (tick) begin
                  if (cnt_q == last_cnt) begin
                     phase_q <= HAS_REARM ? PH_REARM : PH_IDLE;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            PH_REARM: begin
               if (tick) begin
                  if (cnt_q == RARM_LAST) begin
                     phase_q <= PH_IDLE;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: begin
               phase_q <= PH_START;
               cnt_q   <= '0;
            end
         endcase
      end
   end

   assign active = (phase_q == PH_ACTIVE);
   assign ready  = (phase_q != PH_START);

   // R1: the final tick of the programmed count ends the pulse
   a_r1_ends_on_count: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_ACTIVE && tick && cnt_q == last_cnt && !(RETRIG && trig_edge))
      |=> phase_q != PH_ACTIVE);

   // R3: without retriggering an edge leaves the count alone
   a_r3_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (!RETRIG && phase_q == PH_ACTIVE && trig_edge && !tick) |=> $stable(cnt_q));

   // R4: no pulse can begin straight out of the rearm window
   a_r4_rearm_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_REARM) |=> phase_q != PH_ACTIVE);

   // R5: a retrigger restarts the count and keeps the pulse active
   a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (RETRIG && phase_q == PH_ACTIVE && trig_edge)
      |=> (phase_q == PH_ACTIVE && cnt_q == '0));

   // R7: start-up never leads straight into a pulse
   a_r7_start_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_START) |=> (phase_q == PH_START || phase_q == PH_IDLE));

   // R9: without a tick an active pulse is frozen
   a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_ACTIVE && !tick && !trig_edge)
      |=> (phase_q == PH_ACTIVE && $stable(cnt_q)));
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
   import oneshot_pkg::*;
#(
   parameter bit RISE_TRIG     = 1'b1,
   parameter bit RETRIG        = 1'b1,
   parameter int SEL_W         = 3,
   parameter int STEP_LOG2     = 3,
   parameter int SYNC_STAGES   = 2,
   parameter int STARTUP_TICKS = 500,
   parameter int REARM_TICKS   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             trig_in,
   input  logic [SEL_W-1:0] width_sel,
   input  logic             inv_pol,
   output logic             pulse_out
);
   localparam int DIV_W   = STEP_LOG2 * (2 ** SEL_W - 1) + 1;
   localparam int START_W = $clog2(STARTUP_TICKS + 1);
   localparam int RARM_W  = $clog2(REARM_TICKS + 1);
   localparam int CNT_W   = max_int(DIV_W, max_int(START_W, RARM_W));

   if (SEL_W < 1 || STEP_LOG2 < 1) begin : g_bad_sel
      $error("oneshot_timer: SEL_W and STEP_LOG2 must be positive");
   end

   logic             trig_edge;
   logic [CNT_W-1:0] last_cnt;
   logic             active;
   logic             ready;

   trig_edge_det #(
      .STAGES    (SYNC_STAGES),
      .RISE_TRIG (RISE_TRIG)
   ) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (trig_in),
      .edge_o (trig_edge)
   );

   width_select #(
      .SEL_W     (SEL_W),
      .STEP_LOG2 (STEP_LOG2),
      .CNT_W     (CNT_W)
   ) u_width (
      .sel      (width_sel),
      .last_cnt (last_cnt)
   );

   oneshot_core #(
      .CNT_W         (CNT_W),
      .STARTUP_TICKS (STARTUP_TICKS),
      .REARM_TICKS   (REARM_TICKS),
      .RETRIG        (RETRIG)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_en),
      .trig_edge (trig_edge),
      .last_cnt  (last_cnt),
      .active    (active),
      .ready     (ready)
   );

   assign pulse_out = ready & (active ^ inv_pol);
endmodule

// File: tb/oneshot_timer_test.sv
module oneshot_timer_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b1;
   logic       trig_a = 1'b0;
   logic       trig_b = 1'b1;
   logic [2:0] width_sel = 3'd0;
   logic       inv_pol = 1'b1;
   logic       out_a;
   logic       out_b;
   logic       mon_en = 1'b0;
   int         n_chk = 0;
   int         n_fail = 0;
   int         run_a = 0;
   int         run_b = 0;
   int         q_a[$];
   int         q_b[$];

   always #4 clk = ~clk;

   oneshot_timer #(.RISE_TRIG(1'b1), .RETRIG(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .trig_in(trig_a),
      .width_sel(width_sel), .inv_pol(inv_pol), .pulse_out(out_a));

   oneshot_timer #(.RISE_TRIG(1'b0), .RETRIG(1'b0)) uut_nr (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .trig_in(trig_b),
      .width_sel(width_sel), .inv_pol(inv_pol), .pulse_out(out_b));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: measure active widths and compare with the queued expectations
   always @(posedge clk) begin
      #2;
      if (mon_en) begin
         if (out_a != inv_pol) run_a++;
         else if (run_a > 0) begin
            if (q_a.size() == 0) chk(1'b0, "R1 extra pulse on uut", run_a, 0);
            else begin
               int e_a;
               e_a = q_a.pop_front();
               chk(run_a == e_a, "R1 width uut", run_a, e_a);
            end
            run_a = 0;
         end
         if (out_b != inv_pol) run_b++;
         else if (run_b > 0) begin
            if (q_b.size() == 0) chk(1'b0, "R3 extra pulse on uut_nr", run_b, 0);
            else begin
               int e_b;
               e_b = q_b.pop_front();
               chk(run_b == e_b, "R1 width uut_nr", run_b, e_b);
            end
            run_b = 0;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_up();
   end

   initial begin
      cyc(4);
      rst_n = 1'b1;
      chk(out_a == 1'b0, "R7 low at reset", out_a, 0);
      cyc(50);
      trig_a = 1'b1; trig_b = 1'b0;         // edges during start-up: ignored
      cyc(5);
      trig_a = 1'b0; trig_b = 1'b1;
      cyc(444);                              // negedge 499 after release
      chk(out_a == 1'b0, "R7 still low uut", out_a, 0);
      chk(out_b == 1'b0, "R7 still low uut_nr", out_b, 0);
      cyc(1);                                // negedge 500
      chk(out_a == 1'b1, "R8 idle high uut", out_a, 1);
      chk(out_b == 1'b1, "R8 idle high uut_nr", out_b, 1);
      cyc(5);
      chk(out_a == 1'b1, "R7 start-up edge ignored", out_a, 1);
      mon_en = 1'b1;
      inv_pol = 1'b0;
      cyc(3);
      chk(out_a == 1'b0, "R6 idle low with pol 0", out_a, 0);

      // R10 latency, code 1 -> 8 ticks
      width_sel = 3'd1;
      q_a.push_back(8);
      trig_a = 1'b1;
      cyc(2);
      chk(out_a == 1'b0, "R10 not yet active", out_a, 0);
      cyc(1);
      chk(out_a == 1'b1, "R10 active after third edge", out_a, 1);
      cyc(2);
      trig_a = 1'b0;
      cyc(30);

      // R1 widths for codes 0..5
      for (int k = 0; k <= 5; k++) begin
         width_sel = 3'(k);
         q_a.push_back(1 << (3 * k));
         trig_a = 1'b1;
         cyc(2);
         trig_a = 1'b0;
         cyc((1 << (3 * k)) + 20);
      end

      // R2: a falling trigger edge does nothing on the rising-edge instance
      width_sel = 3'd1;
      q_a.push_back(8);
      trig_a = 1'b1;
      cyc(20);
      trig_a = 1'b0;
      cyc(10);
      chk(out_a == 1'b0, "R2 falling edge ignored", out_a, 0);
      cyc(10);

      // R5 retrigger: edges 5 cycles apart -> 5 + 8
      q_a.push_back(13);
      trig_a = 1'b1; cyc(2); trig_a = 1'b0; cyc(3);
      trig_a = 1'b1; cyc(2); trig_a = 1'b0;
      cyc(40);
      // R5 repeated: five edges 4 apart -> 16 + 8
      q_a.push_back(24);
      for (int j = 0; j < 5; j++) begin
         trig_a = 1'b1; cyc(2); trig_a = 1'b0; cyc(2);
      end
      cyc(40);

      // R6 active-low pulses
      inv_pol = 1'b1;
      cyc(3);
      chk(out_a == 1'b1, "R6 idle high with pol 1", out_a, 1);
      width_sel = 3'd0;
      q_a.push_back(1);
      trig_a = 1'b1; cyc(2); trig_a = 1'b0; cyc(20);
      width_sel = 3'd2;
      q_a.push_back(64);
      trig_a = 1'b1; cyc(3);
      chk(out_a == 1'b0, "R6 low-going pulse", out_a, 0);
      trig_a = 1'b0; cyc(90);
      inv_pol = 1'b0;
      cyc(3);

      // R9 stalled tick: 3 + 20 stalled + 5 cycles
      width_sel = 3'd1;
      q_a.push_back(28);
      trig_a = 1'b1; cyc(2); trig_a = 1'b0; cyc(4);
      tick_en = 1'b0;
      cyc(10);
      chk(out_a == 1'b1, "R9 held while stalled", out_a, 1);
      cyc(10);
      tick_en = 1'b1;
      cyc(40);

      // R2 falling-edge instance
      q_b.push_back(8);
      trig_b = 1'b0; cyc(3);
      chk(out_b == 1'b1, "R2 falling edge accepted", out_b, 1);
      cyc(10); trig_b = 1'b1; cyc(10);
      chk(out_b == 1'b0, "R2 rising edge ignored", out_b, 0);
      cyc(10);

      // R3 non-retrigger: second edge 5 later ignored
      q_b.push_back(8);
      trig_b = 1'b0; cyc(3); trig_b = 1'b1; cyc(2);
      trig_b = 1'b0; cyc(2); trig_b = 1'b1;
      cyc(30);

      // R4 rearm: edge 10 after is blocked
      q_b.push_back(8);
      trig_b = 1'b0; cyc(3); trig_b = 1'b1; cyc(7);
      trig_b = 1'b0; cyc(3); trig_b = 1'b1; cyc(1);
      chk(out_b == 1'b0, "R4 edge in rearm ignored", out_b, 0);
      cyc(30);
      // R4 edge 11 after is accepted
      q_b.push_back(8);
      q_b.push_back(8);
      trig_b = 1'b0; cyc(3); trig_b = 1'b1; cyc(8);
      trig_b = 1'b0; cyc(3); trig_b = 1'b1; cyc(1);
      chk(out_b == 1'b1, "R4 edge after rearm accepted", out_b, 1);
      cyc(40);

      chk(q_a.size() == 0, "R1 missing pulses uut", q_a.size(), 0);
      chk(q_b.size() == 0, "R3 missing pulses uut_nr", q_b.size(), 0);
      finish_up();
   end
endmodule